// File: doc/BRIEF.md
# Minute-and-Day Nibble Counter

This block keeps a running time-of-day clock as two 12-bit fields: a minute-of-day count, normally 0 to 1439, and a day count that wraps at 4096. Each field is stored as three 4-bit nibbles in a small nibble register file. A host reads and writes that file one nibble at a time through a shared address port. The minute field is one binary count, not an hours/minutes pair.

Time moves forward in one of two ways. A single-cycle minute tick adds one minute. An advance request adds a burst of N elapsed minutes in one cycle, which lets the block catch up after a stretch of time has been measured elsewhere. Both use the same add, wrap and carry path. When the minute sum reaches a full day, one full day is subtracted from it and one day is carried into the day field.

Top module: `minute_day_counter`

## Requirements
- R1: After reset, all six nibble registers (addresses 0x10 to 0x15) read 0.
- R2: Nibble layout is little-endian. Minutes bits [3:0], [7:4] and [11:8] sit at 0x10, 0x11 and 0x12. Days bits [3:0], [7:4] and [11:8] sit at 0x13, 0x14 and 0x15. A write (`wrEn` high) to one of these addresses replaces only that nibble. Any other address reads 0, and a write to it changes nothing.
- R3: A minute tick adds one minute. A tick at minute 1439 gives minute 0 and adds one day.
- R4: An advance of N (`advValid` high) adds N mod 1440 to the minutes and floor(N/1440) to the days.
- R5: When the minute sum is 1440 or more, 1440 is subtracted from it and one extra day is added.
- R6: An advance of N = 0 leaves every register unchanged. A tick in the same cycle is also dropped.
- R7: The day count wraps modulo 4096.
- R8: A write to 0x10-0x15 takes priority over a tick or an advance in the same cycle. Only the written nibble changes.
- R9: An advance takes priority over a tick in the same cycle. The tick is dropped.
- R10: A minute value at or above 1440 that was loaded directly is corrected on the next step. 1440 is subtracted once, the result is kept to 12 bits, and one day is added. For example, 1440 ticked gives 1, and 4095 ticked gives 2656.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| minuteTick | input | 1 | One-minute step strobe |
| advValid | input | 1 | Advance request strobe |
| advN | input | ADV_W | Elapsed minutes for the advance |
| wrEn | input | 1 | Nibble write strobe |
| regAddr | input | ADDR_W | Nibble address for read and write |
| wrData | input | 4 | Nibble write data |
| rdData | output | 4 | Nibble at regAddr (combinational) |

## Verification
The bench checks the day boundary at 1439. A design that compared against the wrong limit would either skip a day or produce minute 1440. Large advances are checked where the remainder pushes the minute sum past a full day, which catches a missing carry or a quotient and remainder that were swapped. Same-cycle collisions are checked: write with tick, advance with tick, and zero advance with tick. A priority error shows up as a doubled step or a lost write. The day field is driven through 4095. Minutes loaded at 1440 and at 4095 are ticked, so a design that wrapped to zero or clamped, instead of subtracting once, produces values that differ from the expected ones.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  localparam int NIB_W      = 4;
  localparam int FIELD_NIBS = 3;
  localparam int FIELD_W    = NIB_W * FIELD_NIBS;
  localparam int SEL_W      = $clog2(2 * FIELD_NIBS);

  // Strobes from control to datapath
  typedef struct packed {
    logic             nibLoad;
    logic [SEL_W-1:0] nibSel;
    logic             rdHit;
    logic [SEL_W-1:0] rdSel;
    logic             stepEn;
  } mdcStb_t;
endpackage

// File: rtl/mdc_ctl.sv
module mdc_ctl
  import mdc_pkg::*;
#(
  parameter int MIN_PER_DAY = 1440,
  parameter int ADV_W       = 20,
  parameter int ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10,
  localparam int MIN_W      = $clog2(MIN_PER_DAY)
) (
  input  logic              minuteTick,
  input  logic              advValid,
  input  logic [ADV_W-1:0]  advN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output mdcStb_t           stb,
  output logic [MIN_W-1:0]  stepMin,
  output logic [FIELD_W-1:0] stepDay
);
  localparam logic [ADV_W-1:0]  DAY_LEN = ADV_W'(MIN_PER_DAY);
  localparam logic [ADDR_W-1:0] SPAN    = ADDR_W'(2 * FIELD_NIBS);

  logic [ADDR_W-1:0] offset;
  logic              inRange;
  logic [ADV_W-1:0]  stepAmt;
  logic [ADV_W-1:0]  rem;
  logic [ADV_W-1:0]  quo;

  always_comb begin
    offset  = regAddr - BASE_ADDR;
    inRange = (regAddr >= BASE_ADDR) && (offset < SPAN);
    stepAmt = advValid ? advN : ADV_W'(1);
    rem     = stepAmt % DAY_LEN;
    quo     = stepAmt / DAY_LEN;
    stepMin = MIN_W'(rem);
    stepDay = FIELD_W'(quo);

    stb.nibLoad = wrEn && inRange;
    stb.nibSel  = offset[SEL_W-1:0];
    stb.rdHit   = inRange;
    stb.rdSel   = offset[SEL_W-1:0];
    // write beats advance, advance beats tick
    stb.stepEn  = !stb.nibLoad && (advValid ? (advN != '0) : minuteTick);
  end
endmodule

// File: rtl/mdc_datapath.sv
module mdc_datapath
  import mdc_pkg::*;
#(
  parameter int MIN_PER_DAY = 1440,
  localparam int MIN_W      = $clog2(MIN_PER_DAY)
) (
  input  logic               clk,
  input  logic               rstN,
  input  mdcStb_t            stb,
  input  logic [MIN_W-1:0]   stepMin,
  input  logic [FIELD_W-1:0] stepDay,
  input  logic [NIB_W-1:0]   wrData,
  output logic [FIELD_W-1:0] minCount,
  output logic [FIELD_W-1:0] dayCount,
  output logic [NIB_W-1:0]   rdData
);
  localparam logic [FIELD_W:0] DAY_LEN = (FIELD_W+1)'(MIN_PER_DAY);

  logic [FIELD_W:0]   minSum;
  logic               carry;
  logic [FIELD_W-1:0] nextMin;
  logic [FIELD_W-1:0] nextDay;

  always_comb begin
    minSum  = {1'b0, minCount} + (FIELD_W+1)'(stepMin);
    carry   = minSum >= DAY_LEN;
    nextMin = carry ? FIELD_W'(minSum - DAY_LEN) : minSum[FIELD_W-1:0];
    nextDay = dayCount + stepDay + FIELD_W'(carry);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      minCount <= '0;
      dayCount <= '0;
    end else if (stb.nibLoad) begin
      for (int k = 0; k < FIELD_NIBS; k++) begin
        if (stb.nibSel == SEL_W'(k))              minCount[k*NIB_W +: NIB_W] <= wrData;
        if (stb.nibSel == SEL_W'(k + FIELD_NIBS)) dayCount[k*NIB_W +: NIB_W] <= wrData;
      end
    end else if (stb.stepEn) begin
      minCount <= nextMin;
      dayCount <= nextDay;
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.rdHit) begin
      for (int k = 0; k < FIELD_NIBS; k++) begin
        if (stb.rdSel == SEL_W'(k))              rdData = minCount[k*NIB_W +: NIB_W];
        if (stb.rdSel == SEL_W'(k + FIELD_NIBS)) rdData = dayCount[k*NIB_W +: NIB_W];
      end
    end
  end
endmodule

// File: rtl/minute_day_counter.sv
module minute_day_counter
  import mdc_pkg::*;
#(
  parameter int MIN_PER_DAY = 1440,
  parameter int ADV_W       = 20,
  parameter int ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              minuteTick,
  input  logic              advValid,
  input  logic [ADV_W-1:0]  advN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [3:0]        wrData,
  output logic [3:0]        rdData
);
  localparam int MIN_W = $clog2(MIN_PER_DAY);

  mdcStb_t            stb;
  logic [MIN_W-1:0]   stepMin;
  logic [FIELD_W-1:0] stepDay;
  logic [FIELD_W-1:0] minCount;
  logic [FIELD_W-1:0] dayCount;

  mdc_ctl #(
    .MIN_PER_DAY(MIN_PER_DAY), .ADV_W(ADV_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_ctl (
    .minuteTick(minuteTick), .advValid(advValid), .advN(advN),
    .wrEn(wrEn), .regAddr(regAddr),
    .stb(stb), .stepMin(stepMin), .stepDay(stepDay)
  );

  mdc_datapath #(.MIN_PER_DAY(MIN_PER_DAY)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .stepMin(stepMin), .stepDay(stepDay),
    .wrData(wrData), .minCount(minCount), .dayCount(dayCount), .rdData(rdData)
  );
endmodule

// File: rtl/minute_day_counter_chk.sv
module minute_day_counter_chk
  import mdc_pkg::*;
#(
  parameter int ADV_W  = 20,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input logic               clk,
  input logic               rstN,
  input logic               minuteTick,
  input logic               advValid,
  input logic [ADV_W-1:0]   advN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [3:0]         wrData,
  input logic [FIELD_W-1:0] minCount,
  input logic [FIELD_W-1:0] dayCount
);
  logic wrHit;
  logic quiet;
  logic tickOnly;
  assign wrHit    = wrEn && (regAddr >= BASE_ADDR) && (regAddr < BASE_ADDR + ADDR_W'(2*FIELD_NIBS));
  assign quiet    = !wrHit && (advValid ? (advN == '0) : !minuteTick);
  assign tickOnly = !wrHit && !advValid && minuteTick;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    quiet |=> $stable(minCount) && $stable(dayCount));

  p_tick_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tickOnly && minCount < FIELD_W'(1439)) |=>
      (minCount == $past(minCount) + FIELD_W'(1)) && $stable(dayCount));

  p_tick_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tickOnly && minCount == FIELD_W'(1439)) |=>
      (minCount == '0) && (dayCount == $past(dayCount) + FIELD_W'(1)));

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == BASE_ADDR) |=>
      (minCount[3:0] == $past(wrData)) && $stable(dayCount));

  p_in_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrHit && minCount < FIELD_W'(1440)) |=> minCount < FIELD_W'(1440));
endmodule

bind minute_day_counter minute_day_counter_chk #(
  .ADV_W(ADV_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .minuteTick(minuteTick), .advValid(advValid), .advN(advN),
  .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
  .minCount(minCount), .dayCount(dayCount)
);

// File: tb/minute_day_counter_bench.sv
module minute_day_counter_bench;
  localparam int ADV_W = 20;

  localparam logic [2:0] OP_WR = 3'd0, OP_TICK = 3'd1, OP_ADV = 3'd2,
                         OP_WR_TICK = 3'd3, OP_ADV_TICK = 3'd4;

  typedef struct packed {
    logic [2:0]       op;
    logic [7:0]       addr;
    logic [ADV_W-1:0] arg;
    logic [11:0]      expMin;
    logic [11:0]      expDay;
    logic [7:0]       req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{OP_TICK,     8'h00, 20'd1,       12'd1,    12'd0,   8'd3},  // R3
    '{OP_ADV,      8'h00, 20'd100,     12'd101,  12'd0,   8'd4},  // R4
    '{OP_ADV,      8'h00, 20'd4325,    12'd106,  12'd3,   8'd4},  // R4 days part
    '{OP_WR,       8'h10, 20'hF,       12'd111,  12'd3,   8'd2},  // R2 low nibble
    '{OP_WR,       8'h11, 20'h9,       12'd159,  12'd3,   8'd2},  // R2 mid nibble
    '{OP_WR,       8'h12, 20'h5,       12'd1439, 12'd3,   8'd2},  // R2 high nibble
    '{OP_TICK,     8'h00, 20'd1,       12'd0,    12'd4,   8'd3},  // R3 day boundary
    '{OP_WR,       8'h12, 20'h5,       12'd1280, 12'd4,   8'd2},  // R2
    '{OP_ADV,      8'h00, 20'd300,     12'd140,  12'd5,   8'd5},  // R5 carry
    '{OP_ADV_TICK, 8'h00, 20'd0,       12'd140,  12'd5,   8'd6},  // R6 zero with tick
    '{OP_ADV,      8'h00, 20'd0,       12'd140,  12'd5,   8'd6},  // R6
    '{OP_WR_TICK,  8'h13, 20'h2,       12'd140,  12'd2,   8'd8},  // R8
    '{OP_ADV_TICK, 8'h00, 20'd10,      12'd150,  12'd2,   8'd9},  // R9
    '{OP_WR,       8'h15, 20'hF,       12'd150,  12'd3842,8'd2},  // R2 day high
    '{OP_WR,       8'h14, 20'hF,       12'd150,  12'd4082,8'd2},  // R2 day mid
    '{OP_WR,       8'h13, 20'hF,       12'd150,  12'd4095,8'd2},  // R2 day low
    '{OP_WR,       8'h12, 20'h5,       12'd1430, 12'd4095,8'd2},  // R2
    '{OP_WR,       8'h10, 20'hF,       12'd1439, 12'd4095,8'd2},  // R2
    '{OP_TICK,     8'h00, 20'd1,       12'd0,    12'd0,   8'd7},  // R7 day wrap
    '{OP_WR,       8'h20, 20'hA,       12'd0,    12'd0,   8'd2},  // R2 unmapped write
    '{OP_WR,       8'h11, 20'hA,       12'd160,  12'd0,   8'd2},  // R2
    '{OP_WR,       8'h12, 20'h5,       12'd1440, 12'd0,   8'd10}, // R10 load 1440
    '{OP_TICK,     8'h00, 20'd1,       12'd1,    12'd1,   8'd10}, // R10
    '{OP_WR,       8'h10, 20'hF,       12'd15,   12'd1,   8'd2},  // R2
    '{OP_WR,       8'h11, 20'hF,       12'd255,  12'd1,   8'd2},  // R2
    '{OP_WR,       8'h12, 20'hF,       12'd4095, 12'd1,   8'd10}, // R10 load 4095
    '{OP_TICK,     8'h00, 20'd1,       12'd2656, 12'd2,   8'd10}, // R10
    '{OP_ADV,      8'h00, 20'd1048575, 12'd1471, 12'd731, 8'd4}   // R4 largest burst
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             minuteTick = 1'b0;
  logic             advValid = 1'b0;
  logic [ADV_W-1:0] advN = '0;
  logic             wrEn = 1'b0;
  logic [7:0]       regAddr = '0;
  logic [3:0]       wrData = '0;
  logic [3:0]       rdData;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  minute_day_counter u_minute_day_counter (
    .clk(clk), .rstN(rstN), .minuteTick(minuteTick), .advValid(advValid), .advN(advN),
    .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic readField(input logic [7:0] base, output logic [11:0] val);
    for (int k = 0; k < 3; k++) begin
      regAddr = base + 8'(k);
      #1;
      val[k*4 +: 4] = rdData;
    end
  endtask

  task automatic checkBoth(input string tag, input int expMin, input int expDay);
    logic [11:0] m;
    logic [11:0] d;
    readField(8'h10, m);
    readField(8'h13, d);
    check({tag, " minutes"}, int'(m), expMin);
    check({tag, " days"}, int'(d), expDay);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkBoth("R1 reset", 0, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wrEn       = (VECS[i].op == OP_WR) || (VECS[i].op == OP_WR_TICK);
      regAddr    = VECS[i].addr;
      wrData     = VECS[i].arg[3:0];
      minuteTick = (VECS[i].op == OP_TICK) || (VECS[i].op == OP_WR_TICK) || (VECS[i].op == OP_ADV_TICK);
      advValid   = (VECS[i].op == OP_ADV) || (VECS[i].op == OP_ADV_TICK);
      advN       = VECS[i].arg;
      @(negedge clk);
      wrEn = 1'b0; minuteTick = 1'b0; advValid = 1'b0; advN = '0;
      checkBoth($sformatf("R%0d vector %0d", VECS[i].req, i), int'(VECS[i].expMin), int'(VECS[i].expDay));
    end

    // R2: an unmapped address reads zero after a write to it
    regAddr = 8'h20;
    #1;
    check("R2 unmapped read", int'(rdData), 0);
    regAddr = 8'h0F;
    #1;
    check("R2 below-base read", int'(rdData), 0);

    // R1: reset in mid-run clears both fields
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    checkBoth("R1 mid-run reset", 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule